// File: doc/BRIEF.md
# Serial port register file

This block is the software-facing register file of a simple asynchronous serial port. A processor reaches it through a 32-bit bus. Writes take effect on a clock edge and reads are combinational on the byte address. The receiver, the transmitter and the baud generator sit outside the block. They hand over line status as levels and error events as single-cycle pulses. In return they take one-cycle command strobes, the latched mode and divisor fields, the character-compare settings, and a single interrupt line.

The block holds an interrupt mask that software never writes directly. One register sets mask bits where the written word has ones, and another clears them. The same bit layout is used for the mask and for the status word. Error events are latched into sticky flags until software pulses the error-clear command. Configuration can be frozen by a write-protect register. That register only accepts a write that carries the 24-bit key `0x554152` in bits 31:8.

Top module: `sport_regs`

## Requirements
- R1: Reads of the write-only registers return zero. These are control (0x00), mask-set (0x08), mask-clear (0x0C) and transmit data (0x1C). Reads of any unmapped address also return zero. Writes to the read-only registers have no effect: mask (0x10), status (0x14) and receive data (0x18).
- R2: A write to control (0x00) raises one-cycle strobes in the cycle after the write edge, from these bits: 2 receiver reset, 3 transmitter reset, 4 receiver enable, 5 receiver disable, 6 transmitter enable, 7 transmitter disable, 8 error clear, 12 request clear. When an enable bit and its matching disable bit are both written, only the disable strobe is raised. Control reads as zero.
- R3: A write to 0x08 sets each mask bit where the data bit is one. A write to 0x0C clears each mask bit where the data bit is one. Zero bits change nothing. Only bits in 0x000082E3 can be set. The mask reads back at 0x10.
- R4: Status at 0x14 places its bits as follows: bit 0 receive ready, bit 1 transmit ready, bit 9 transmitter empty (these three are live inputs), bit 5 overrun, bit 6 framing error, bit 7 parity error, bit 15 compare match. The four error/match bits are sticky and are set by a pulse on their event input.
- R5: The error-clear strobe clears the four sticky flags at the edge that ends the strobe cycle. An event pulse in that same cycle leaves its flag set.
- R6: `irq_o` is high exactly when status AND mask is nonzero.
- R7: The mode register (0x04) keeps only the bits in 0x0000DE10. Its field outputs are: filter on from bit 4, parity select from bits 11:9, baud source from bit 12, channel mode from bits 15:14.
- R8: The divisor register (0x20) holds bits 15:0. The compare register (0x24) keeps the bits in 0x00FF50FF. Its field outputs are: first value from bits 7:0, gate from bit 12, parity compare from bit 14, second value from bits 23:16.
- R9: The write-protect register (0xE4) updates its enable (bit 0) only when bits 31:8 of the written word equal 0x554152. It reads back the enable bit, with bits 31:8 reading as zero.
- R10: While write protection is enabled, writes to mode, divisor and compare are ignored. Writes to control, mask-set, mask-clear and transmit data still act.
- R11: A write to transmit data (0x1C) raises `tx_load_o` for one cycle after the write edge, with the written low byte on `tx_byte_o`. A read of 0x18 returns the `rx_byte_i` input in bits 7:0.
- R12: After reset, all registers, strobes, flags and the interrupt line are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write enable for the current bus cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_ready_i | input | 1 | Receiver holds a character (level) |
| tx_ready_i | input | 1 | Transmitter can take a character (level) |
| tx_empty_i | input | 1 | Transmitter fully idle (level) |
| ev_overrun_i | input | 1 | Overrun event pulse |
| ev_frame_i | input | 1 | Framing error event pulse |
| ev_parity_i | input | 1 | Parity error event pulse |
| ev_match_i | input | 1 | Compare match event pulse |
| rx_byte_i | input | 8 | Last received character |
| rx_reset_o | output | 1 | Receiver reset strobe |
| tx_reset_o | output | 1 | Transmitter reset strobe |
| rx_enable_o | output | 1 | Receiver enable strobe |
| rx_disable_o | output | 1 | Receiver disable strobe |
| tx_enable_o | output | 1 | Transmitter enable strobe |
| tx_disable_o | output | 1 | Transmitter disable strobe |
| err_clear_o | output | 1 | Error flag clear strobe |
| req_clear_o | output | 1 | Request clear strobe |
| tx_load_o | output | 1 | Transmit character load strobe |
| tx_byte_o | output | 8 | Character to transmit |
| filter_on_o | output | 1 | Receive line filter select |
| parity_sel_o | output | 3 | Parity type select |
| baud_src_o | output | 1 | Baud clock source select |
| chan_mode_o | output | 2 | Channel (echo/loopback) mode |
| divisor_o | output | 16 | Baud clock divisor |
| match_lo_o | output | 8 | First compare value |
| match_hi_o | output | 8 | Second compare value |
| match_gate_o | output | 1 | Compare gates reception |
| match_parity_o | output | 1 | Compare includes parity |
| wprot_o | output | 1 | Write protection active |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume the bus and event inputs are known at every clock edge. They also assume no bus write arrives while the internal reset synchronizer still holds the block in reset. The bench meets both assumptions. It drives every input on the falling edge, starts from all-zero values, and waits several cycles after releasing reset before its first write.

The random part of the bench restricts addresses to the mapped registers plus one unmapped address. It supplies the correct protection key on about half of the protect-register writes, so that both locked and unlocked phases occur. Event pulses are sparse, so most error-clear commands meet a quiet cycle, but some collide with an event.

// File: rtl/sport_regs_pkg.sv
package sport_regs_pkg;

  localparam int DATA_W = 32;

  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MODE  = 'h04;
  localparam int OFS_ISET  = 'h08;
  localparam int OFS_ICLR  = 'h0C;
  localparam int OFS_IMASK = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_RXD   = 'h18;
  localparam int OFS_TXD   = 'h1C;
  localparam int OFS_DIV   = 'h20;
  localparam int OFS_MATCH = 'h24;
  localparam int OFS_WPROT = 'hE4;

  // control bit positions
  localparam int CB_RX_RST  = 2;
  localparam int CB_TX_RST  = 3;
  localparam int CB_RX_EN   = 4;
  localparam int CB_RX_DIS  = 5;
  localparam int CB_TX_EN   = 6;
  localparam int CB_TX_DIS  = 7;
  localparam int CB_ERR_CLR = 8;
  localparam int CB_REQ_CLR = 12;

  // status / mask bit positions
  localparam int SB_RX_READY = 0;
  localparam int SB_TX_READY = 1;
  localparam int SB_TX_EMPTY = 9;

  localparam int NUM_STICKY = 4;
  // sticky flags: overrun, framing, parity, compare match
  localparam int STICKY_POS [NUM_STICKY] = '{5, 6, 7, 15};

  localparam logic [DATA_W-1:0] IRQ_VALID   = 32'h0000_82E3;
  localparam logic [DATA_W-1:0] MODE_VALID  = 32'h0000_DE10;
  localparam logic [DATA_W-1:0] MATCH_VALID = 32'h00FF_50FF;
  localparam logic [DATA_W-1:0] STICKY_MASK = 32'h0000_80E0;

  localparam logic [23:0] KEY_DEFAULT = 24'h554152;

  typedef struct packed {
    logic req_clr;
    logic err_clr;
    logic tx_dis;
    logic tx_en;
    logic rx_dis;
    logic rx_en;
    logic tx_rst;
    logic rx_rst;
  } cmd_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_MODE, SEL_ISET, SEL_ICLR, SEL_IMASK,
    SEL_STAT, SEL_RXD, SEL_TXD, SEL_DIV, SEL_MATCH, SEL_WPROT
  } reg_sel_e;

endpackage

// File: rtl/sport_rst_sync.sv
module sport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sport_cmd.sv
module sport_cmd
  import sport_regs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_ctrl,
  input  logic              wr_txd,
  input  logic [DATA_W-1:0] wdata,
  output cmd_t              cmd_q,
  output logic              tx_load_q,
  output logic [BYTE_W-1:0] tx_byte_q
);
  cmd_t              cmd_n;
  logic              tx_load_n;
  logic [BYTE_W-1:0] tx_byte_n;
  logic              tx_byte_ce;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata[DATA_W-1:CB_REQ_CLR+1], wdata[CB_REQ_CLR-1:CB_ERR_CLR+1]};

  // decode: disable beats enable when both are written
  always_comb begin
    cmd_n = '0;
    if (wr_ctrl) begin
      cmd_n.rx_rst  = wdata[CB_RX_RST];
      cmd_n.tx_rst  = wdata[CB_TX_RST];
      cmd_n.rx_dis  = wdata[CB_RX_DIS];
      cmd_n.rx_en   = wdata[CB_RX_EN] & ~wdata[CB_RX_DIS];
      cmd_n.tx_dis  = wdata[CB_TX_DIS];
      cmd_n.tx_en   = wdata[CB_TX_EN] & ~wdata[CB_TX_DIS];
      cmd_n.err_clr = wdata[CB_ERR_CLR];
      cmd_n.req_clr = wdata[CB_REQ_CLR];
    end
  end

  always_comb begin
    tx_load_n  = wr_txd;
    tx_byte_ce = wr_txd;
    tx_byte_n  = wdata[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      tx_load_q <= 1'b0;
    end else begin
      cmd_q     <= cmd_n;
      tx_load_q <= tx_load_n;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_byte_q <= '0;
    end else if (tx_byte_ce) begin
      tx_byte_q <= tx_byte_n;
    end
  end
endmodule

// File: rtl/sport_irq.sv
module sport_irq
  import sport_regs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  wr_iset,
  input  logic                  wr_iclr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic                  rx_ready,
  input  logic                  tx_ready,
  input  logic                  tx_empty,
  input  logic [NUM_STICKY-1:0] events,
  input  logic                  flag_clr,
  output logic [DATA_W-1:0]     mask_q,
  output logic [DATA_W-1:0]     status,
  output logic                  irq
);
  logic [DATA_W-1:0]     mask_n;
  logic                  mask_ce;
  logic [NUM_STICKY-1:0] flag_q;
  logic [NUM_STICKY-1:0] flag_n;

  // mask: separate set and clear paths, never direct write
  always_comb begin
    mask_ce = wr_iset | wr_iclr;
    mask_n  = mask_q;
    if (wr_iset) mask_n = mask_q | (wdata & IRQ_VALID);
    if (wr_iclr) mask_n = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_n;
    end
  end

  // sticky flags: a new event outranks a clear in the same cycle
  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_flag
    assign flag_n[i] = events[i] | (flag_q[i] & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_n;
    end
  end

  always_comb begin
    status = '0;
    status[SB_RX_READY] = rx_ready;
    status[SB_TX_READY] = tx_ready;
    status[SB_TX_EMPTY] = tx_empty;
    for (int i = 0; i < NUM_STICKY; i++) begin
      status[STICKY_POS[i]] = flag_q[i];
    end
  end

  assign irq = |(status & mask_q);
endmodule

// File: rtl/sport_cfg.sv
module sport_cfg
  import sport_regs_pkg::*;
#(
  parameter int                DIV_W     = 16,
  parameter logic [DATA_W-1:0] MODE_RST  = '0,
  parameter logic [DIV_W-1:0]  DIV_RST   = '0,
  parameter logic [DATA_W-1:0] MATCH_RST = '0,
  parameter logic [23:0]       WP_KEY    = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_mode,
  input  logic              wr_div,
  input  logic              wr_match,
  input  logic              wr_wprot,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] match_q,
  output logic              wprot_q
);
  localparam int KEY_LSB = DATA_W - 24;

  logic              cfg_open;
  logic              key_ok;
  logic              mode_ce, div_ce, match_ce, wprot_ce;
  logic [DATA_W-1:0] mode_n, match_n;
  logic [DIV_W-1:0]  div_n;
  logic              wprot_n;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[KEY_LSB-1:1];

  always_comb begin
    cfg_open = ~wprot_q;
    key_ok   = (wdata[DATA_W-1:KEY_LSB] == WP_KEY);
    mode_ce  = wr_mode & cfg_open;
    div_ce   = wr_div & cfg_open;
    match_ce = wr_match & cfg_open;
    wprot_ce = wr_wprot & key_ok;
    mode_n   = wdata & MODE_VALID;
    div_n    = wdata[DIV_W-1:0];
    match_n  = wdata & MATCH_VALID;
    wprot_n  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RST & MODE_VALID;
    else if (mode_ce) mode_q <= mode_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= DIV_RST;
    else if (div_ce) div_q <= div_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) match_q <= MATCH_RST & MATCH_VALID;
    else if (match_ce) match_q <= match_n;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) wprot_q <= 1'b0;
    else if (wprot_ce) wprot_q <= wprot_n;
  end
endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_regs_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DIV_W  = 16,
  parameter logic [23:0] WP_KEY = KEY_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_ready_i,
  input  logic              tx_ready_i,
  input  logic              tx_empty_i,
  input  logic              ev_overrun_i,
  input  logic              ev_frame_i,
  input  logic              ev_parity_i,
  input  logic              ev_match_i,
  input  logic [7:0]        rx_byte_i,
  output logic              rx_reset_o,
  output logic              tx_reset_o,
  output logic              rx_enable_o,
  output logic              rx_disable_o,
  output logic              tx_enable_o,
  output logic              tx_disable_o,
  output logic              err_clear_o,
  output logic              req_clear_o,
  output logic              tx_load_o,
  output logic [7:0]        tx_byte_o,
  output logic              filter_on_o,
  output logic [2:0]        parity_sel_o,
  output logic              baud_src_o,
  output logic [1:0]        chan_mode_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [7:0]        match_lo_o,
  output logic [7:0]        match_hi_o,
  output logic              match_gate_o,
  output logic              match_parity_o,
  output logic              wprot_o,
  output logic              irq_o
);
  logic              rst_sync_n;
  reg_sel_e          sel;
  cmd_t              cmd_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] mode_q;
  logic [DATA_W-1:0] match_q;
  logic [DIV_W-1:0]  div_q;
  logic [NUM_STICKY-1:0] events;

  sport_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // address decode
  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFS_MODE))  sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(OFS_ISET))  sel = SEL_ISET;
    else if (bus_addr == ADDR_W'(OFS_ICLR))  sel = SEL_ICLR;
    else if (bus_addr == ADDR_W'(OFS_IMASK)) sel = SEL_IMASK;
    else if (bus_addr == ADDR_W'(OFS_STAT))  sel = SEL_STAT;
    else if (bus_addr == ADDR_W'(OFS_RXD))   sel = SEL_RXD;
    else if (bus_addr == ADDR_W'(OFS_TXD))   sel = SEL_TXD;
    else if (bus_addr == ADDR_W'(OFS_DIV))   sel = SEL_DIV;
    else if (bus_addr == ADDR_W'(OFS_MATCH)) sel = SEL_MATCH;
    else if (bus_addr == ADDR_W'(OFS_WPROT)) sel = SEL_WPROT;
  end

  assign events = {ev_match_i, ev_parity_i, ev_frame_i, ev_overrun_i};

  sport_cmd #(.BYTE_W(8)) u_cmd (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wr_ctrl   (bus_wr && sel == SEL_CTRL),
    .wr_txd    (bus_wr && sel == SEL_TXD),
    .wdata     (bus_wdata),
    .cmd_q     (cmd_q),
    .tx_load_q (tx_load_o),
    .tx_byte_q (tx_byte_o)
  );

  sport_irq u_irq (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_iset  (bus_wr && sel == SEL_ISET),
    .wr_iclr  (bus_wr && sel == SEL_ICLR),
    .wdata    (bus_wdata),
    .rx_ready (rx_ready_i),
    .tx_ready (tx_ready_i),
    .tx_empty (tx_empty_i),
    .events   (events),
    .flag_clr (cmd_q.err_clr),
    .mask_q   (mask_q),
    .status   (status),
    .irq      (irq_o)
  );

  sport_cfg #(.DIV_W(DIV_W), .WP_KEY(WP_KEY)) u_cfg (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_mode  (bus_wr && sel == SEL_MODE),
    .wr_div   (bus_wr && sel == SEL_DIV),
    .wr_match (bus_wr && sel == SEL_MATCH),
    .wr_wprot (bus_wr && sel == SEL_WPROT),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .div_q    (div_q),
    .match_q  (match_q),
    .wprot_q  (wprot_o)
  );

  // read mux: write-only and unmapped locations return zero
  always_comb begin
    case (sel)
      SEL_MODE:  bus_rdata = mode_q;
      SEL_IMASK: bus_rdata = mask_q;
      SEL_STAT:  bus_rdata = status;
      SEL_RXD:   bus_rdata = {24'b0, rx_byte_i};
      SEL_DIV:   bus_rdata = 32'(div_q);
      SEL_MATCH: bus_rdata = match_q;
      SEL_WPROT: bus_rdata = {31'b0, wprot_o};
      default:   bus_rdata = '0;
    endcase
  end

  assign rx_reset_o   = cmd_q.rx_rst;
  assign tx_reset_o   = cmd_q.tx_rst;
  assign rx_enable_o  = cmd_q.rx_en;
  assign rx_disable_o = cmd_q.rx_dis;
  assign tx_enable_o  = cmd_q.tx_en;
  assign tx_disable_o = cmd_q.tx_dis;
  assign err_clear_o  = cmd_q.err_clr;
  assign req_clear_o  = cmd_q.req_clr;

  assign filter_on_o    = mode_q[4];
  assign parity_sel_o   = mode_q[11:9];
  assign baud_src_o     = mode_q[12];
  assign chan_mode_o    = mode_q[15:14];
  assign divisor_o      = div_q;
  assign match_lo_o     = match_q[7:0];
  assign match_gate_o   = match_q[12];
  assign match_parity_o = match_q[14];
  assign match_hi_o     = match_q[23:16];
endmodule

// File: rtl/sport_regs_chk.sv
module sport_regs_chk
  import sport_regs_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [23:0] WP_KEY = KEY_DEFAULT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              rx_reset_o,
  input logic              rx_enable_o,
  input logic              rx_disable_o,
  input logic              tx_enable_o,
  input logic              tx_disable_o,
  input logic              err_clear_o,
  input logic [31:0]       mask_q,
  input logic [31:0]       status,
  input logic [3:0]        events,
  input logic [15:0]       divisor_o,
  input logic              wprot_o,
  input logic              irq_o
);
  AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable_o |-> !rx_disable_o); // R2
  AST_TX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable_o |-> !tx_disable_o); // R2
  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_o |-> $past(bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CB_RX_RST])); // R2
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ISET)) |=>
      ((mask_q & $past(bus_wdata) & IRQ_VALID) == ($past(bus_wdata) & IRQ_VALID))); // R3
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_ICLR)) |=> ((mask_q & $past(bus_wdata)) == 32'h0)); // R3
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear_o && events == 4'b0) |=> ((status & STICKY_MASK) == 32'h0)); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 32'h0) |-> !irq_o); // R6
  AST_KEY_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_WPROT)) |-> (bus_rdata[31:8] == 24'h0)); // R9
  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_WPROT) && bus_wdata[31:8] != WP_KEY) |=> $stable(wprot_o)); // R9
  AST_LOCKED_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_DIV) && wprot_o) |=> $stable(divisor_o)); // R10
endmodule

bind sport_regs sport_regs_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .rx_reset_o   (rx_reset_o),
  .rx_enable_o  (rx_enable_o),
  .rx_disable_o (rx_disable_o),
  .tx_enable_o  (tx_enable_o),
  .tx_disable_o (tx_disable_o),
  .err_clear_o  (err_clear_o),
  .mask_q       (mask_q),
  .status       (status),
  .events       (events),
  .divisor_o    (divisor_o),
  .wprot_o      (wprot_o),
  .irq_o        (irq_o)
);

// File: tb/sport_regs_bench.sv
module sport_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] KEY = 24'h554152;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_ready_i, tx_ready_i, tx_empty_i;
  logic        ev_overrun_i, ev_frame_i, ev_parity_i, ev_match_i;
  logic [7:0]  rx_byte_i;
  logic        rx_reset_o, tx_reset_o, rx_enable_o, rx_disable_o;
  logic        tx_enable_o, tx_disable_o, err_clear_o, req_clear_o;
  logic        tx_load_o;
  logic [7:0]  tx_byte_o;
  logic        filter_on_o;
  logic [2:0]  parity_sel_o;
  logic        baud_src_o;
  logic [1:0]  chan_mode_o;
  logic [15:0] divisor_o;
  logic [7:0]  match_lo_o, match_hi_o;
  logic        match_gate_o, match_parity_o, wprot_o, irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_regs u_sport_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_ready_i(rx_ready_i), .tx_ready_i(tx_ready_i), .tx_empty_i(tx_empty_i),
    .ev_overrun_i(ev_overrun_i), .ev_frame_i(ev_frame_i),
    .ev_parity_i(ev_parity_i), .ev_match_i(ev_match_i), .rx_byte_i(rx_byte_i),
    .rx_reset_o(rx_reset_o), .tx_reset_o(tx_reset_o),
    .rx_enable_o(rx_enable_o), .rx_disable_o(rx_disable_o),
    .tx_enable_o(tx_enable_o), .tx_disable_o(tx_disable_o),
    .err_clear_o(err_clear_o), .req_clear_o(req_clear_o),
    .tx_load_o(tx_load_o), .tx_byte_o(tx_byte_o),
    .filter_on_o(filter_on_o), .parity_sel_o(parity_sel_o),
    .baud_src_o(baud_src_o), .chan_mode_o(chan_mode_o),
    .divisor_o(divisor_o), .match_lo_o(match_lo_o), .match_hi_o(match_hi_o),
    .match_gate_o(match_gate_o), .match_parity_o(match_parity_o),
    .wprot_o(wprot_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the register state
  logic [31:0] m_mask, m_mode, m_match;
  logic [15:0] m_div;
  logic        m_wp;
  logic [3:0]  m_flags;   // overrun, frame, parity, match
  logic [7:0]  m_cmd;     // rx_rst,tx_rst,rx_en,rx_dis,tx_en,tx_dis,err,req (bit 0 first)
  logic        m_txl;
  logic [7:0]  m_txb;
  logic [2:0]  m_lv;      // rx_ready, tx_ready, tx_empty
  logic [7:0]  m_rxb;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'h0;
    s[0] = m_lv[0]; s[1] = m_lv[1]; s[9] = m_lv[2];
    s[5] = m_flags[0]; s[6] = m_flags[1]; s[7] = m_flags[2]; s[15] = m_flags[3];
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h04: return m_mode;
      8'h10: return m_mask;
      8'h14: return exp_status();
      8'h18: return {24'h0, m_rxb};
      8'h20: return {16'h0, m_div};
      8'h24: return m_match;
      8'hE4: return {31'h0, m_wp};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h04: return "R7";
      8'h10: return "R3";
      8'h14: return "R4";
      8'h18: return "R11";
      8'h20, 8'h24: return "R8";
      8'hE4: return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [7:0] addr_at(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h04;  2: return 8'h08;  3: return 8'h0C;
      4: return 8'h10;  5: return 8'h14;  6: return 8'h18;  7: return 8'h1C;
      8: return 8'h20;  9: return 8'h24;  10: return 8'hE4;
      default: return 8'h40;
    endcase
  endfunction

  task automatic model_edge(input logic wr, input logic [7:0] a, input logic [31:0] d, input logic [3:0] ev);
    m_flags = ev | (m_cmd[6] ? 4'b0 : m_flags);
    m_cmd = 8'h0;
    m_txl = 1'b0;
    if (wr) begin
      case (a)
        8'h00: m_cmd = {d[12], d[8], d[7], d[6] & ~d[7], d[5], d[4] & ~d[5], d[3], d[2]};
        8'h08: m_mask = m_mask | (d & 32'h0000_82E3);
        8'h0C: m_mask = m_mask & ~d;
        8'h1C: begin m_txl = 1'b1; m_txb = d[7:0]; end
        8'h04: if (!m_wp) m_mode = d & 32'h0000_DE10;
        8'h20: if (!m_wp) m_div = d[15:0];
        8'h24: if (!m_wp) m_match = d & 32'h00FF_50FF;
        8'hE4: if (d[31:8] == KEY) m_wp = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic check_outputs();
    chk("R2", "strobes", {24'h0, req_clear_o, err_clear_o, tx_disable_o, tx_enable_o,
        rx_disable_o, rx_enable_o, tx_reset_o, rx_reset_o}, {24'h0, m_cmd});
    chk("R11", "tx_load", 32'(tx_load_o), 32'(m_txl));
    if (m_txl) chk("R11", "tx_byte", 32'(tx_byte_o), 32'(m_txb));
    chk("R6", "irq", 32'(irq_o), 32'(|(exp_status() & m_mask)));
    chk("R7", "mode fields", 32'({chan_mode_o, baud_src_o, parity_sel_o, filter_on_o}),
        32'({m_mode[15:14], m_mode[12], m_mode[11:9], m_mode[4]}));
    chk("R8", "divisor", 32'(divisor_o), 32'(m_div));
    chk("R8", "compare fields", 32'({match_hi_o, match_parity_o, match_gate_o, match_lo_o}),
        32'({m_match[23:16], m_match[14], m_match[12], m_match[7:0]}));
    chk("R9", "wprot", 32'(wprot_o), 32'(m_wp));
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] ev, input logic [2:0] lv, input logic [7:0] rb,
                      input logic [7:0] ra);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    {ev_match_i, ev_parity_i, ev_frame_i, ev_overrun_i} = ev;
    {tx_empty_i, tx_ready_i, rx_ready_i} = lv;
    rx_byte_i = rb;
    @(posedge clk);
    model_edge(wr, a, d, ev);
    m_lv = lv; m_rxb = rb;
    @(negedge clk);
    bus_wr = 1'b0;
    {ev_match_i, ev_parity_i, ev_frame_i, ev_overrun_i} = 4'b0;
    check_outputs();
    bus_addr = ra;
    #1;
    chk(tag_of(ra), "read", bus_rdata, exp_read(ra));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] ra);
    step(1'b1, a, d, 4'b0, m_lv, m_rxb, ra);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = 32'h0;
    {rx_ready_i, tx_ready_i, tx_empty_i} = 3'b0;
    {ev_overrun_i, ev_frame_i, ev_parity_i, ev_match_i} = 4'b0;
    rx_byte_i = 8'h0;
    m_mask = 0; m_mode = 0; m_match = 0; m_div = 0; m_wp = 0; m_flags = 0;
    m_cmd = 0; m_txl = 0; m_txb = 0; m_lv = 0; m_rxb = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    for (int i = 0; i < 12; i++) begin
      bus_addr = addr_at(i); #1;
      chk("R12", "reset read", bus_rdata, 32'h0);
    end
    chk("R12", "reset irq/strobes", 32'({irq_o, rx_reset_o, tx_reset_o, rx_enable_o, rx_disable_o,
        tx_enable_o, tx_disable_o, err_clear_o, req_clear_o, tx_load_o, wprot_o}), 32'h0);

    // R2: every control bit, enable with disable together
    wr(8'h00, 32'h0000_11FC, 8'h00);
    chk("R2", "disable wins", 32'({rx_enable_o, rx_disable_o, tx_enable_o, tx_disable_o}), 32'b0101);
    wr(8'h00, 32'h0000_0050, 8'h00);
    step(1'b0, 8'h00, 32'h0, 4'b0, m_lv, m_rxb, 8'h00);

    // R3: set all, zero writes, single clear, writes to read-only ignored (R1)
    wr(8'h08, 32'hFFFF_FFFF, 8'h10);
    wr(8'h08, 32'h0, 8'h10);
    wr(8'h0C, 32'h0, 8'h10);
    wr(8'h0C, 32'h0000_0001, 8'h10);
    wr(8'h10, 32'h0, 8'h10);
    wr(8'h14, 32'hFFFF_FFFF, 8'h14);

    // R4/R5/R6: flags, clear with colliding event
    step(1'b0, 8'h00, 32'h0, 4'b1111, 3'b101, 8'hA5, 8'h14);
    wr(8'h00, 32'h0000_0100, 8'h14);
    step(1'b0, 8'h00, 32'h0, 4'b1000, m_lv, m_rxb, 8'h14);
    chk("R5", "event beats clear", bus_rdata & 32'h0000_80E0, 32'h0000_8000);
    wr(8'h00, 32'h0000_0100, 8'h14);
    step(1'b0, 8'h00, 32'h0, 4'b0, m_lv, m_rxb, 8'h14);
    chk("R5", "flags cleared", bus_rdata & 32'h0000_80E0, 32'h0);

    // R9/R10: bad key, lock, locked writes, unlock
    wr(8'h20, 32'h0000_1234, 8'h20);
    wr(8'hE4, 32'h5541_5301, 8'hE4);
    wr(8'hE4, {KEY, 8'h01}, 8'hE4);
    wr(8'h04, 32'hFFFF_FFFF, 8'h04);
    chk("R10", "mode locked", bus_rdata, 32'h0);
    wr(8'h20, 32'h0000_FFFF, 8'h20);
    chk("R10", "divisor locked", bus_rdata, 32'h0000_1234);
    wr(8'h00, 32'h0000_0004, 8'h00);
    chk("R10", "control live while locked", 32'(rx_reset_o), 32'h1);
    wr(8'h1C, 32'h0000_003C, 8'h1C);
    wr(8'h08, 32'h0000_0001, 8'h10);
    chk("R10", "mask live while locked", bus_rdata & 32'h1, 32'h1);
    wr(8'hE4, {KEY, 8'h00}, 8'hE4);
    wr(8'h24, 32'hFFFF_FFFF, 8'h24);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic        w;
      logic [7:0]  a;
      logic [31:0] d;
      logic [3:0]  ev;
      logic [2:0]  lv;
      w  = ($urandom % 4) != 0;
      a  = addr_at($urandom % 12);
      d  = $urandom;
      if (a == 8'hE4 && ($urandom % 2) == 1) d = {KEY, 7'h0, (($urandom % 3) == 0)};
      ev = (($urandom % 8) == 0) ? 4'($urandom) : 4'b0;
      lv = (($urandom % 5) == 0) ? 3'($urandom) : m_lv;
      step(w, a, d, ev, lv, 8'($urandom), addr_at($urandom % 12));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule